// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the storage and arithmetic half of a 32-bit processor that spends several clock cycles on each instruction. It keeps the program counter, the instruction register, two operand latches, an arithmetic result latch and a memory read latch. Around these sit a 32-word register file, a five-function ALU, immediate widening and shifting, and one small word-addressed memory that serves both instruction fetch and data access. Every register loads under control inputs of the kind an external sequencer produces, one step per cycle.

A sequencer reads the opcode and the ALU zero flag and drives the select and enable inputs step by step: fetch, decode, then an execute, memory or write-back step as the instruction needs. Besides results taken from the ALU or from memory, the register write data can come from a path that places the 16-bit immediate in the upper half of a word. This lets the upper-immediate instruction finish in three cycles. A fill port writes the memory before a program runs.

Top module: `mc_datapath`

## Requirements
- R1: While reset is asserted, the program counter, the instruction register, the result latch and every register-file entry are cleared to zero.
- R2: With mem_addr_sel=0, alu_a_sel=0 (PC), alu_b_sel=1 (constant 4), alu_func=0 (add), next_pc_sel=0, pc_load=1 and ir_load=1, one edge loads the instruction register with the memory word at the PC and loads the PC with PC+4. The opcode output is instruction bits [31:26].
- R3: The instruction register changes only on an edge where ir_load is 1.
- R4: The operand latches load every cycle from the registers named by instruction bits [25:21] and [20:16]. With alu_a_sel=0 and alu_b_sel=3, the result latch loads PC plus the sign-extended low 16 instruction bits shifted left by two.
- R5: alu_func encodes 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). alu_a_sel=1 selects operand latch A. alu_b_sel selects 0 latch B, 1 the constant 4, 2 the sign-extended immediate, 3 that value shifted left by two. The result latch loads the ALU result every cycle.
- R6: zero_o is 1 exactly when the current ALU result is all zeros.
- R7: With pc_load=0, the PC changes only when pc_load_if_zero=1 and zero_o=1; it then loads the source picked by next_pc_sel.
- R8: mem_addr_sel=1 addresses memory with the result latch and 0 with the PC; the memory latch captures the addressed word every cycle. mem_store=1 writes latch B into the addressed word at the edge.
- R9: With reg_write=1, the destination is bits [20:16] when rd_sel=0 and bits [15:11] when rd_sel=1. wb_sel selects the write data: 0 the result latch, 1 the memory latch, 2 the low 16 instruction bits followed by 16 zeros.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: next_pc_sel selects 0 the ALU result, 1 the result latch, 2 the PC's top four bits joined to instruction bits [25:0] and two zero bits.
- R12: A register written on an edge is seen by the operand latches only from the following cycle. On that edge they capture the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write fill_data into memory |
| fill_addr | input | 6 | Fill word index |
| fill_data | input | 32 | Fill word |
| pc_load | input | 1 | Unconditional PC update |
| pc_load_if_zero | input | 1 | PC update when zero_o is 1 |
| mem_addr_sel | input | 1 | Memory address: 0 PC, 1 result latch |
| mem_store | input | 1 | Store latch B to memory |
| ir_load | input | 1 | Load instruction register |
| rd_sel | input | 1 | Destination field select |
| reg_write | input | 1 | Register file write enable |
| wb_sel | input | 2 | Register write data select |
| alu_a_sel | input | 1 | ALU operand A select |
| alu_b_sel | input | 2 | ALU operand B select |
| alu_func | input | 3 | ALU function |
| next_pc_sel | input | 2 | PC source select |
| opcode_o | output | 6 | Instruction bits [31:26] |
| zero_o | output | 1 | ALU result is zero |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Instruction register |
| alu_out_o | output | 32 | Result latch |

## Verification
Two things can happen to one register in the same cycle: a write-back into it, and its capture into the operand latches. A program adds a register to itself and writes the sum back to that same register, so the write-back cycle also reads the register being written. Two more add steps follow. The first must show the doubled old value, because the latches captured the pre-write contents. The second must show the doubled new value, and a design that forwards the write data, or fails to capture it, gives a different result.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_func_e;

    typedef enum logic [1:0] {
        WB_RESULT = 2'd0,
        WB_MEMORY = 2'd1,
        WB_UPPER  = 2'd2
    } wb_src_e;

    typedef enum logic [1:0] {
        NPC_ALU    = 2'd0,
        NPC_LATCH  = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_src_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] result;
        logic [XLEN-1:0] mdata;
    } dp_regs_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   func,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (alu_func_e'(func))
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx_a,
    input  logic [AW-1:0] rd_idx_b,
    output logic [W-1:0]  rd_val_a,
    output logic [W-1:0]  rd_val_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_val
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            regs_q[wr_idx] <= wr_val;
        end
    end

    always_comb begin
        rd_val_a = (rd_idx_a == '0) ? '0 : regs_q[rd_idx_a];
        rd_val_b = (rd_idx_b == '0) ? '0 : regs_q[rd_idx_b];
    end
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [W-1:0]  fill_data,
    input  logic [31:0]   addr,
    input  logic          store,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0]  words_q [WORDS];
    logic [AW-1:0] idx;
    logic          unused_addr_bits;

    assign idx              = addr[AW+1:2];
    assign unused_addr_bits = ^{addr[31:AW+2], addr[1:0]};

    always_ff @(posedge clk) begin
        if (fill_en) begin
            words_q[fill_addr] <= fill_data;
        end else if (store) begin
            words_q[idx] <= wdata;
        end
    end

    assign rdata = words_q[idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [MEM_AW-1:0] fill_addr,
    input  logic [31:0]       fill_data,
    input  logic              pc_load,
    input  logic              pc_load_if_zero,
    input  logic              mem_addr_sel,
    input  logic              mem_store,
    input  logic              ir_load,
    input  logic              rd_sel,
    input  logic              reg_write,
    input  logic [1:0]        wb_sel,
    input  logic              alu_a_sel,
    input  logic [1:0]        alu_b_sel,
    input  logic [2:0]        alu_func,
    input  logic [1:0]        next_pc_sel,
    output logic [5:0]        opcode_o,
    output logic              zero_o,
    output logic [31:0]       pc_o,
    output logic [31:0]       ir_o,
    output logic [31:0]       alu_out_o
);
    dp_regs_t q, d;

    logic [XLEN-1:0]   imm_sext;
    logic [XLEN-1:0]   imm_upper;
    logic [XLEN-1:0]   jump_tgt;
    logic [XLEN-1:0]   alu_a, alu_b, alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   mem_addr, mem_rdata;
    logic [REG_AW-1:0] rf_wr_idx;
    logic [XLEN-1:0]   rf_wr_val;
    logic [XLEN-1:0]   rf_rd_a, rf_rd_b;
    logic [XLEN-1:0]   pc_next;

    // Immediate and jump target formation
    always_comb begin
        imm_sext  = {{16{q.ir[15]}}, q.ir[15:0]};
        imm_upper = {q.ir[15:0], 16'h0000};
        jump_tgt  = {q.pc[31:28], q.ir[25:0], 2'b00};
    end

    // Operand selection
    always_comb begin
        alu_a = alu_a_sel ? q.opa : q.pc;
        unique case (alu_b_sel)
            2'd0:    alu_b = q.opb;
            2'd1:    alu_b = 32'd4;
            2'd2:    alu_b = imm_sext;
            default: alu_b = {imm_sext[XLEN-3:0], 2'b00};
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .func (alu_func),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign mem_addr = mem_addr_sel ? q.result : q.pc;

    mc_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
        .clk       (clk),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .addr      (mem_addr),
        .store     (mem_store),
        .wdata     (q.opb),
        .rdata     (mem_rdata)
    );

    // Register write port selection
    always_comb begin
        rf_wr_idx = rd_sel ? q.ir[15:11] : q.ir[20:16];
        unique case (wb_src_e'(wb_sel))
            WB_MEMORY: rf_wr_val = q.mdata;
            WB_UPPER:  rf_wr_val = imm_upper;
            default:   rf_wr_val = q.result;
        endcase
    end

    mc_regfile #(.W(XLEN), .N(32)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_a (q.ir[25:21]),
        .rd_idx_b (q.ir[20:16]),
        .rd_val_a (rf_rd_a),
        .rd_val_b (rf_rd_b),
        .wr_en    (reg_write),
        .wr_idx   (rf_wr_idx),
        .wr_val   (rf_wr_val)
    );

    // PC source selection
    always_comb begin
        unique case (npc_src_e'(next_pc_sel))
            NPC_LATCH: pc_next = q.result;
            NPC_JUMP:  pc_next = jump_tgt;
            default:   pc_next = alu_y;
        endcase
    end

    // Next-state computation
    always_comb begin
        d        = q;
        d.opa    = rf_rd_a;
        d.opb    = rf_rd_b;
        d.result = alu_y;
        d.mdata  = mem_rdata;
        if (ir_load) d.ir = mem_rdata;
        if (pc_load || (pc_load_if_zero && alu_zero)) d.pc = pc_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign opcode_o  = q.ir[31:26];
    assign zero_o    = alu_zero;
    assign pc_o      = q.pc;
    assign ir_o      = q.ir;
    assign alu_out_o = q.result;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pc_load,
    input logic        pc_load_if_zero,
    input logic        ir_load,
    input logic [1:0]  next_pc_sel,
    input logic        zero_o,
    input logic [31:0] pc_o,
    input logic [31:0] ir_o,
    input logic [31:0] alu_out_o,
    input logic [31:0] rs_val
);
    assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(ir_o));

    assert_pc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && !pc_load_if_zero) |=> $stable(pc_o));

    assert_branch_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && pc_load_if_zero && !zero_o) |=> $stable(pc_o));

    assert_branch_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && pc_load_if_zero && zero_o && next_pc_sel == 2'd1)
        |=> pc_o == $past(alu_out_o));

    assert_jump_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && next_pc_sel == 2'd2)
        |=> pc_o == {$past(pc_o[31:28]), $past(ir_o[25:0]), 2'b00});

    assert_reg_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_o[25:21] == 5'd0) |-> rs_val == 32'd0);
endmodule

bind mc_datapath mc_datapath_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pc_load         (pc_load),
    .pc_load_if_zero (pc_load_if_zero),
    .ir_load         (ir_load),
    .next_pc_sel     (next_pc_sel),
    .zero_o          (zero_o),
    .pc_o            (pc_o),
    .ir_o            (ir_o),
    .alu_out_o       (alu_out_o),
    .rs_val          (rf_rd_a)
);

// File: tb/test_mc_datapath.sv
module test_mc_datapath;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WORDS      = 64;
    localparam logic [2:0] F_ADD = 3'd0, F_SUB = 3'd1, F_AND = 3'd2, F_OR = 3'd3, F_SLT = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_en = 1'b0;
    logic [5:0]  fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        pc_load = 0, pc_load_if_zero = 0, mem_addr_sel = 0, mem_store = 0;
    logic        ir_load = 0, rd_sel = 0, reg_write = 0, alu_a_sel = 0;
    logic [1:0]  wb_sel = 0, alu_b_sel = 0, next_pc_sel = 0;
    logic [2:0]  alu_func = 0;
    logic [5:0]  opcode_o;
    logic        zero_o;
    logic [31:0] pc_o, ir_o, alu_out_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    logic [31:0] m_pc = 0, m_ir = 0, m_a = 0, m_b = 0, m_res = 0, m_md = 0;
    logic [31:0] m_rf  [32];
    logic [31:0] m_mem [WORDS];

    mc_datapath #(.MEM_WORDS(WORDS)) i_mc_datapath (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_alu(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f);
        case (f)
            F_ADD:   return a + b;
            F_SUB:   return a - b;
            F_AND:   return a & b;
            F_OR:    return a | b;
            F_SLT:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // One control step: apply controls, check zero, advance the model with the edge, compare state.
    task automatic cyc(input logic pw, input logic pwz, input logic asel, input logic st,
                       input logic irw, input logic rds, input logic rw, input logic [1:0] wbs,
                       input logic sa, input logic [1:0] sb, input logic [2:0] f, input logic [1:0] ps);
        logic [31:0] opa, opb, res, addr, rdat, sx, nxt, wd, na, nb;
        logic [4:0]  wa;
        logic        z;
        pc_load = pw; pc_load_if_zero = pwz; mem_addr_sel = asel; mem_store = st;
        ir_load = irw; rd_sel = rds; reg_write = rw; wb_sel = wbs;
        alu_a_sel = sa; alu_b_sel = sb; alu_func = f; next_pc_sel = ps;
        #1;
        sx  = {{16{m_ir[15]}}, m_ir[15:0]};
        opa = sa ? m_a : m_pc;
        case (sb)
            2'd0: opb = m_b;
            2'd1: opb = 32'd4;
            2'd2: opb = sx;
            default: opb = sx << 2;
        endcase
        res = ref_alu(opa, opb, f);
        z   = (res == 32'd0);
        check({cur_req, "/R6 zero"}, {31'd0, zero_o}, {31'd0, z});
        addr = asel ? m_res : m_pc;
        rdat = m_mem[addr[7:2]];
        case (ps)
            2'd1: nxt = m_res;
            2'd2: nxt = {m_pc[31:28], m_ir[25:0], 2'b00};
            default: nxt = res;
        endcase
        wa = rds ? m_ir[15:11] : m_ir[20:16];
        case (wbs)
            2'd1: wd = m_md;
            2'd2: wd = {m_ir[15:0], 16'h0};
            default: wd = m_res;
        endcase
        na = m_rf[m_ir[25:21]];
        nb = m_rf[m_ir[20:16]];
        @(posedge clk);
        if (st) m_mem[addr[7:2]] = m_b;
        if (rw && wa != 5'd0) m_rf[wa] = wd;
        if (pw || (pwz && z)) m_pc = nxt;
        if (irw) m_ir = rdat;
        m_res = res; m_md = rdat; m_a = na; m_b = nb;
        @(negedge clk);
        check({cur_req, " pc"}, pc_o, m_pc);
        check({cur_req, " ir"}, ir_o, m_ir);
        check({cur_req, " result"}, alu_out_o, m_res);
        check({cur_req, " opcode"}, {26'd0, opcode_o}, {26'd0, m_ir[31:26]});
    endtask

    task automatic t_fetch();  cur_req = "R2"; cyc(1,0,0,0,1,0,0,2'd0,0,2'd1,F_ADD,2'd0); endtask
    task automatic t_decode(); cur_req = "R4"; cyc(0,0,0,0,0,0,0,2'd0,0,2'd3,F_ADD,2'd0); endtask
    task automatic t_addr();   cur_req = "R8"; cyc(0,0,0,0,0,0,0,2'd0,1,2'd2,F_ADD,2'd0); endtask
    task automatic t_exec(input logic [2:0] f); cur_req = "R5"; cyc(0,0,0,0,0,0,0,2'd0,1,2'd0,f,2'd0); endtask

    task automatic run_lw();
        t_fetch(); t_decode(); t_addr();
        cur_req = "R8"; cyc(0,0,1,0,0,0,0,2'd0,0,2'd0,F_ADD,2'd0);
        cur_req = "R9"; cyc(0,0,0,0,0,0,1,2'd1,0,2'd0,F_ADD,2'd0);
    endtask
    task automatic run_sw();
        t_fetch(); t_decode(); t_addr();
        cur_req = "R8"; cyc(0,0,1,1,0,0,0,2'd0,0,2'd0,F_ADD,2'd0);
    endtask
    task automatic run_r(input logic [2:0] f, input logic [31:0] exp, input string req);
        t_fetch(); t_decode(); t_exec(f);
        check(req, alu_out_o, exp);
        cur_req = "R9"; cyc(0,0,0,0,0,1,1,2'd0,0,2'd0,F_ADD,2'd0);
    endtask
    task automatic run_lui();
        t_fetch(); t_decode();
        cur_req = "R9"; cyc(0,0,0,0,0,0,1,2'd2,0,2'd0,F_ADD,2'd0);
    endtask
    task automatic run_beq();
        t_fetch(); t_decode();
        cur_req = "R7"; cyc(0,1,0,0,0,0,0,2'd0,1,2'd0,F_SUB,2'd1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        for (int i = 0; i < WORDS; i++) m_mem[i] = 32'd0;
        m_mem[0]  = itype(6'h23, 0, 1, 16'd160);
        m_mem[1]  = itype(6'h23, 0, 2, 16'd164);
        m_mem[2]  = rtype(1, 2, 3);
        m_mem[3]  = rtype(2, 1, 4);
        m_mem[4]  = rtype(2, 1, 5);
        m_mem[5]  = rtype(1, 2, 6);
        m_mem[6]  = rtype(1, 2, 7);
        m_mem[7]  = itype(6'h2B, 0, 3, 16'd168);
        m_mem[8]  = itype(6'h23, 0, 8, 16'd168);
        m_mem[9]  = itype(6'h0F, 0, 9, 16'h1234);
        m_mem[10] = rtype(1, 1, 0);
        m_mem[11] = rtype(0, 9, 10);
        m_mem[12] = rtype(8, 0, 11);
        m_mem[13] = itype(6'h04, 1, 2, 16'd5);
        m_mem[14] = itype(6'h04, 1, 1, 16'd2);
        m_mem[17] = {6'h02, 26'd20};
        m_mem[20] = rtype(1, 1, 1);
        m_mem[40] = 32'd7;
        m_mem[41] = 32'hFFFF_FFFB;

        // Fill memory while reset holds the registers
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            fill_en = 1'b1; fill_addr = 6'(i); fill_data = m_mem[i];
        end
        @(negedge clk);
        fill_en = 1'b0;
        @(negedge clk);
        check("R1 pc", pc_o, 32'd0);
        check("R1 ir", ir_o, 32'd0);
        check("R1 result", alu_out_o, 32'd0);
        rst_n = 1'b1;

        run_lw();
        check("R2 pc after fetch", pc_o, 32'd4);
        check("R2 opcode", {26'd0, opcode_o}, 32'h23);
        run_lw();
        run_r(F_ADD, 32'd2, "R5 add");
        check("R3 ir held", ir_o, rtype(1, 2, 3));
        run_r(F_SUB, 32'hFFFF_FFF4, "R5 sub");
        run_r(F_SLT, 32'd1, "R5 slt");
        run_r(F_AND, 32'd3, "R5 and");
        run_r(F_OR, 32'hFFFF_FFFF, "R5 or");
        run_sw();
        run_lw();
        run_lui();
        run_r(F_ADD, 32'd14, "R10 write r0");
        run_r(F_OR, 32'h1234_0000, "R9 upper imm / R10 r0 read");
        run_r(F_ADD, 32'd2, "R8 store then load");
        run_beq();
        check("R7 not taken", pc_o, 32'd56);
        t_fetch(); t_decode();
        check("R4 branch target", alu_out_o, 32'd68);
        cur_req = "R7"; cyc(0,1,0,0,0,0,0,2'd0,1,2'd0,F_SUB,2'd1);
        check("R7 taken", pc_o, 32'd68);
        t_fetch();
        cur_req = "R11"; cyc(1,0,0,0,0,0,0,2'd0,0,2'd0,F_ADD,2'd2);
        check("R11 jump", pc_o, 32'd80);
        run_r(F_ADD, 32'd14, "R12 first add");
        t_exec(F_ADD);
        check("R12 old value captured", alu_out_o, 32'd14);
        t_exec(F_ADD);
        check("R12 new value next cycle", alu_out_o, 32'd28);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule